// File: doc/BRIEF.md
# SMBus Target Protocol Engine

This block is the target side of a two-wire open-drain management bus. It runs in a fast system clock domain. It oversamples the clock and data wires, recognises bus START, repeated START and STOP conditions, and collects the 7-bit target address and the direction bit. It always acknowledges its own address, so a host can use that acknowledge to detect that the device is present. The block drives the wires only through active-high pull-low enables. An enable at 1 pulls the wire low; at 0 the wire is released.

On a write, each data byte is handed to the register side with a one-cycle strobe. The register side then says, per byte, whether the byte is acceptable, and the engine answers ACK or NACK. This lets an invalid command or value be rejected at any byte, including the last one. To give the register side time to decide, the engine can hold the clock low for a fixed, short number of cycles before each data acknowledge. On a read, the engine requests each byte with a one-cycle pulse and shifts it out MSB first. It stops driving after the host refuses a byte.

A watchdog counts how long the clock wire stays low. If the clock is held low too long, the transfer is abandoned and both wires are released.

Top module: `smbus_target`

## Requirements
- R1: START (SDA falls while SCL is high) begins address reception from any state, including in the middle of a transfer. STOP (SDA rises while SCL is high) returns the engine to idle with both enables low. Clock pulses with no preceding START get no response.
- R2: The first byte after START is 7 address bits, MSB first, followed by a direction bit (1 = read). When the address equals OWN_ADDR, sda_oe is high during the ninth clock, whatever the value of rx_accept.
- R3: A byte that does not match OWN_ADDR gets no acknowledge. After it, the engine drives neither wire and raises neither strobe until the next START.
- R4: In a write transfer, each data byte produces one rx_stb pulse after its eighth SCL rise, with the byte on rx_byte. rx_cmd is 1 for the first data byte after the address and 0 for later bytes.
- R5: For every write data byte, including the last one, rx_accept is sampled at the decision point. A 1 gives ACK (sda_oe high in the ninth clock). A 0 gives NACK (SDA released). Reception continues after a NACK.
- R6: In a read transfer, tx_req pulses at the SCL rise of each acknowledge bit that precedes a byte. These are the target's address acknowledge and each host ACK. tx_byte is taken at the next SCL fall and shifted out MSB first, with sda_oe equal to the inverse of each bit.
- R7: A host NACK after a read byte makes the engine release SDA. After that it issues no further tx_req until the next START.
- R8: When STRETCH_CYC is nonzero, scl_oe is high for exactly STRETCH_CYC consecutive cycles once per write data byte, beginning after the SCL fall that ends the eighth bit. scl_oe is high at no other time.
- R9: When the synchronised SCL has been low for TIMEOUT_CYC consecutive cycles, tmo_flag pulses once. On the next cycle both enables are low and the engine is idle. The count clears while SCL is high.
- R10: sda_oe changes only while the synchronised SCL is low.
- R11: After reset, sda_oe, scl_oe, rx_stb, tx_req and tmo_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire as seen on the pin |
| sda_i | input | 1 | Bus data wire as seen on the pin |
| scl_oe | output | 1 | Pull the clock wire low (clock stretch) |
| sda_oe | output | 1 | Pull the data wire low |
| rx_byte | output | 8 | Last received write data byte |
| rx_stb | output | 1 | One-cycle pulse: rx_byte holds a new data byte |
| rx_cmd | output | 1 | The strobed byte is the first byte after the address |
| rx_accept | input | 1 | 1 = acknowledge the current write byte, 0 = refuse it |
| tx_byte | input | 8 | Next byte to send in a read transfer |
| tx_req | output | 1 | One-cycle pulse: present the next read byte on tx_byte |
| tmo_flag | output | 1 | One-cycle pulse: clock-low timeout fired |

## Verification
The properties assume a well-behaved bus host. The host changes SDA only while SCL is low, except at START and STOP. Each clock phase it produces lasts longer than the synchroniser delay plus the stretch window. It never drives SDA high while the target pulls it low. The sequence the properties check also assumes that rx_accept is stable at the decision point and that tx_byte is stable by the SCL fall after tx_req.

The bench host model keeps within these assumptions by working from 20-cycle half phases. It always releases SDA before it raises SCL, except when it intends a START or STOP. It waits for the clock wire to actually go high, so the target's stretch is respected. It changes rx_accept only between bytes, and it answers tx_req on the following cycle.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
   localparam int unsigned ADDR_W = 7;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BITC_W = $clog2(BYTE_W);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RX_BIT,
      ST_BYTE_END,
      ST_STRETCH,
      ST_ACK_SLOT,
      ST_RD_LOAD,
      ST_RD_BIT,
      ST_RD_MACK,
      ST_SKIP
   } eng_state_t;

   function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                     input logic [ADDR_W-1:0] own);
      return frame[BYTE_W-1:1] == own;
   endfunction
endpackage

// File: rtl/smbt_linesync.sv
module smbt_linesync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int unsigned NLINES = 2;

   logic [NLINES-1:0] line_in;
   logic [NLINES-1:0] line_sync;
   logic [NLINES-1:0] line_prev;

   assign line_in = {sda_i, scl_i};

   genvar g;
   for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-2:0], line_in[g]};
      end
      assign line_sync[g] = pipe[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= '1;
      else        line_prev <= line_sync;
   end

   assign scl_s     = line_sync[0];
   assign sda_s     = line_sync[1];
   assign scl_rise  =  line_sync[0] & ~line_prev[0];
   assign scl_fall  = ~line_sync[0] &  line_prev[0];
   assign start_det =  line_sync[0] & line_prev[0] &  line_prev[1] & ~line_sync[1];
   assign stop_det  =  line_sync[0] & line_prev[0] & ~line_prev[1] &  line_sync[1];
endmodule

// File: rtl/smbt_watchdog.sv
module smbt_watchdog #(
   parameter int unsigned TIMEOUT_CYC = 8_750_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   output logic tmo
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
   localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_cnt <= '0;
      else if (scl_s)           low_cnt <= '0;
      else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
   end

   assign tmo = !scl_s && (low_cnt == LAST);

   assert_tmo_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !tmo);
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
   import smbt_pkg::*;
#(
   parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h2C,
   parameter int unsigned       STRETCH_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              tmo,
   input  logic              rx_accept,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic              rx_stb,
   output logic              rx_cmd,
   output logic              tx_req,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);

   eng_state_t        state;
   logic [BITC_W-1:0] bitc;
   logic [BYTE_W-1:0] sh;
   logic              is_addr;
   logic              rw_q;
   logic              first_q;

   logic st_go, st_decide, st_done, st_hold;

   assign st_go = (state == ST_BYTE_END) && scl_fall && !is_addr &&
                  !tmo && !start_det && !stop_det;

   if (STRETCH_CYC == 0) begin : g_nostretch
      assign st_hold   = 1'b0;
      assign st_decide = st_go;
      assign st_done   = st_go;
   end else begin : g_stretch
      localparam int unsigned SW = $clog2(STRETCH_CYC + 1);
      logic [SW-1:0] st_cnt;
      logic          hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
            st_cnt <= '0;
         end else if (tmo || start_det || stop_det) begin
            hold_q <= 1'b0;
         end else if (st_go) begin
            hold_q <= 1'b1;
            st_cnt <= SW'(STRETCH_CYC - 1);
         end else if (hold_q) begin
            if (st_cnt == '0) hold_q <= 1'b0;
            else              st_cnt <= st_cnt - 1'b1;
         end
      end
      assign st_hold   = hold_q;
      assign st_decide = hold_q && (st_cnt == SW'(1));
      assign st_done   = hold_q && (st_cnt == '0);
   end

   assign scl_oe = st_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitc    <= '0;
         sh      <= '0;
         is_addr <= 1'b0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         sda_oe  <= 1'b0;
         rx_stb  <= 1'b0;
         rx_cmd  <= 1'b0;
         rx_byte <= '0;
         tx_req  <= 1'b0;
      end else begin
         rx_stb <= 1'b0;
         tx_req <= 1'b0;
         if (tmo || stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state   <= ST_RX_BIT;
            is_addr <= 1'b1;
            first_q <= 1'b1;
            bitc    <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_RX_BIT: if (scl_rise) begin
                  sh   <= {sh[BYTE_W-2:0], sda_s};
                  bitc <= bitc + 1'b1;
                  if (bitc == LAST_BIT) begin
                     state <= ST_BYTE_END;
                     if (!is_addr) begin
                        rx_stb  <= 1'b1;
                        rx_byte <= {sh[BYTE_W-2:0], sda_s};
                        rx_cmd  <= first_q;
                        first_q <= 1'b0;
                     end
                  end
               end
               ST_BYTE_END: if (scl_fall) begin
                  if (is_addr) begin
                     if (addr_hit(sh, OWN_ADDR)) begin
                        sda_oe <= 1'b1;
                        rw_q   <= sh[0];
                        state  <= ST_ACK_SLOT;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else begin
                     if (st_decide) sda_oe <= rx_accept;
                     state <= st_done ? ST_ACK_SLOT : ST_STRETCH;
                  end
               end
               ST_STRETCH: begin
                  if (st_decide) sda_oe <= rx_accept;
                  if (st_done)   state  <= ST_ACK_SLOT;
               end
               ST_ACK_SLOT: begin
                  if (scl_rise && is_addr && rw_q) tx_req <= 1'b1;
                  if (scl_fall) begin
                     bitc    <= '0;
                     is_addr <= 1'b0;
                     if (is_addr && rw_q) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        state  <= ST_RD_BIT;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX_BIT;
                     end
                  end
               end
               ST_RD_BIT: if (scl_fall) begin
                  bitc <= bitc + 1'b1;
                  if (bitc == LAST_BIT) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RD_MACK;
                  end else begin
                     sh     <= {sh[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~sh[BYTE_W-2];
                  end
               end
               ST_RD_MACK: if (scl_rise) begin
                  if (!sda_s) begin
                     tx_req <= 1'b1;
                     state  <= ST_RD_LOAD;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_RD_LOAD: if (scl_fall) begin
                  sh     <= tx_byte;
                  sda_oe <= ~tx_byte[BYTE_W-1];
                  bitc   <= '0;
                  state  <= ST_RD_BIT;
               end
               default: ;
            endcase
         end
      end
   end

   assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
   assert_rx_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |-> !rw_q);
   assert_txreq_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> rw_q);
   assert_stretch_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> !scl_s);
endmodule

// File: rtl/smbus_target.sv
module smbus_target
   import smbt_pkg::*;
#(
   parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h2C,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       TIMEOUT_CYC = 8_750_000,
   parameter int unsigned       STRETCH_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_stb,
   output logic              rx_cmd,
   input  logic              rx_accept,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              tx_req,
   output logic              tmo_flag
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 2 or more");
   end
   if (TIMEOUT_CYC < 64) begin : g_bad_tmo
      $error("TIMEOUT_CYC too small");
   end
   if (STRETCH_CYC != 0 && (STRETCH_CYC < 2 || STRETCH_CYC * 4 >= TIMEOUT_CYC)) begin : g_bad_str
      $error("STRETCH_CYC must be 0, or at least 2 and under a quarter of TIMEOUT_CYC");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tmo;

   smbt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smbt_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .tmo   (tmo)
   );

   smbt_engine #(.OWN_ADDR(OWN_ADDR), .STRETCH_CYC(STRETCH_CYC)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .tmo       (tmo),
      .rx_accept (rx_accept),
      .tx_byte   (tx_byte),
      .sda_oe    (sda_oe),
      .scl_oe    (scl_oe),
      .rx_stb    (rx_stb),
      .rx_cmd    (rx_cmd),
      .tx_req    (tx_req),
      .rx_byte   (rx_byte)
   );

   assign tmo_flag = tmo;

   assert_tmo_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> (!sda_oe && !scl_oe));
   assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_stb && tx_req));
endmodule

// File: tb/smbus_target_bench.sv
module smbus_target_bench;
   localparam int HALF = 20;
   localparam int TMO  = 600;
   localparam int STR  = 40;
   localparam logic [6:0] ADDR = 7'h2C;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic scl_oe, sda_oe, rx_stb, rx_cmd, tx_req, tmo_flag, rx_accept;
   logic [7:0] rx_byte, tx_byte;
   logic scl_line, sda_line;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   smbus_target #(.OWN_ADDR(ADDR), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO), .STRETCH_CYC(STR))
   u_smbus_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_stb(rx_stb),
      .rx_cmd(rx_cmd), .rx_accept(rx_accept), .tx_byte(tx_byte), .tx_req(tx_req),
      .tmo_flag(tmo_flag)
   );

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model state: expected strobes, stretch runs, read replies
   logic [7:0] exp_b[$];
   bit         exp_c[$];
   logic [7:0] txq[$];
   int  tmo_seen = 0, txreq_seen = 0, runs_seen = 0, runs_exp = 0, run_len = 0;
   bit  quiet = 0;
   string quiet_req = "R3";
   bit  prev_sda_oe = 0, prev_scl = 1;

   always @(negedge clk) if (rst_n) begin
      if (rx_stb) begin
         if (exp_b.size() == 0) check("R4", "unexpected rx_stb byte", rx_byte, -1);
         else begin
            check("R4", "rx_byte", rx_byte, exp_b.pop_front());
            check("R4", "rx_cmd", rx_cmd, exp_c.pop_front());
         end
      end
      if (tx_req) begin
         txreq_seen++;
         tx_byte = (txq.size() != 0) ? txq.pop_front() : 8'hFF;
      end
      if (tmo_flag) tmo_seen++;
      if (scl_oe) run_len++;
      else if (run_len != 0) begin
         check("R8", "stretch length", run_len, STR);
         runs_seen++;
         run_len = 0;
      end
      if (quiet && (sda_oe || rx_stb || tx_req)) begin
         check(quiet_req, "activity while ignoring", 1, 0);
         quiet = 0;
      end
      if ((sda_oe != prev_sda_oe) && prev_scl && scl_line)
         check("R10", "sda_oe moved with SCL high", 1, 0);
      prev_sda_oe = sda_oe;
      prev_scl    = scl_line;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wait_high();
      while (!scl_line) @(posedge clk);
   endtask

   task automatic bus_start();
      m_sda_low <= 1'b0; wait_cyc(HALF);
      m_scl_low <= 1'b0; wait_cyc(1); wait_high(); wait_cyc(HALF);
      m_sda_low <= 1'b1; wait_cyc(HALF);
      m_scl_low <= 1'b1; wait_cyc(HALF);
   endtask

   task automatic bus_stop();
      m_sda_low <= 1'b1; wait_cyc(HALF);
      m_scl_low <= 1'b0; wait_cyc(1); wait_high(); wait_cyc(HALF);
      m_sda_low <= 1'b0; wait_cyc(HALF);
   endtask

   task automatic clock_bit(input bit b, output bit r);
      m_sda_low <= !b; wait_cyc(HALF);
      m_scl_low <= 1'b0; wait_cyc(1); wait_high(); wait_cyc(HALF/2);
      r = sda_line; wait_cyc(HALF/2);
      m_scl_low <= 1'b1;
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
      clock_bit(1'b1, r);
      ack = !r;
   endtask

   task automatic read_byte(input bit m_ack, output logic [7:0] d);
      bit r;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, r);
         d[i] = r;
      end
      clock_bit(!m_ack, r);
   endtask

   task automatic expect_rx(input logic [7:0] b, input bit c);
      exp_b.push_back(b);
      exp_c.push_back(c);
      runs_exp++;
   endtask

   initial begin
      bit ack;
      logic [7:0] d;
      rst_n = 1'b0; rx_accept = 1'b0; tx_byte = 8'h00;
      wait_cyc(10);
      rst_n <= 1'b1;
      wait_cyc(5);
      check("R11", "reset sda_oe", sda_oe, 0);
      check("R11", "reset scl_oe", scl_oe, 0);
      check("R11", "reset strobes", {rx_stb, tx_req, tmo_flag}, 0);

      // write: address ACK despite rx_accept=0, accepted command, refused last byte
      bus_start();
      write_byte({ADDR, 1'b0}, ack);
      check("R2", "own address ACK with rx_accept low", ack, 1);
      rx_accept <= 1'b1;
      expect_rx(8'h07, 1'b1);
      write_byte(8'h07, ack);
      check("R5", "accepted command ACK", ack, 1);
      rx_accept <= 1'b0;
      expect_rx(8'hA5, 1'b0);
      write_byte(8'hA5, ack);
      check("R5", "refused last byte NACK", ack, 0);
      bus_stop();
      wait_cyc(4);
      check("R1", "released after STOP", sda_oe, 0);

      // clocks without START are ignored
      quiet = 1; quiet_req = "R1";
      m_scl_low <= 1'b1; wait_cyc(HALF);
      write_byte({ADDR, 1'b0}, ack);
      check("R1", "no ACK without START", ack, 0);
      m_sda_low <= 1'b0; wait_cyc(HALF);
      m_scl_low <= 1'b0; wait_cyc(HALF);
      quiet = 0;

      // foreign address
      quiet = 1; quiet_req = "R3";
      bus_start();
      write_byte({7'h11, 1'b0}, ack);
      check("R3", "foreign address ACK", ack, 0);
      write_byte(8'h33, ack);
      check("R3", "byte after foreign address ACK", ack, 0);
      bus_stop();
      quiet = 0;

      // command write then repeated START read
      rx_accept <= 1'b1;
      bus_start();
      write_byte({ADDR, 1'b0}, ack);
      check("R2", "own address ACK", ack, 1);
      expect_rx(8'h10, 1'b1);
      write_byte(8'h10, ack);
      check("R5", "command ACK", ack, 1);
      txq.push_back(8'h5A);
      txq.push_back(8'h3C);
      bus_start();
      write_byte({ADDR, 1'b1}, ack);
      check("R1", "read address ACK after repeated START", ack, 1);
      read_byte(1'b1, d);
      check("R6", "first read byte", d, 8'h5A);
      read_byte(1'b0, d);
      check("R6", "second read byte", d, 8'h3C);
      read_byte(1'b1, d);
      check("R7", "bus released after host NACK", d, 8'hFF);
      check("R7", "tx_req count", txreq_seen, 2);
      bus_stop();

      // clock-low timeout during a read
      txq.push_back(8'h12);
      bus_start();
      write_byte({ADDR, 1'b1}, ack);
      check("R2", "read address ACK", ack, 1);
      wait_cyc(12);
      check("R6", "driving MSB 0 of read byte", sda_oe, 1);
      check("R9", "no early timeout", tmo_seen, 0);
      wait_cyc(TMO + 40);
      check("R9", "timeout pulses", tmo_seen, 1);
      check("R9", "sda released after timeout", sda_oe, 0);
      check("R9", "scl released after timeout", scl_oe, 0);
      m_scl_low <= 1'b0;
      wait_cyc(HALF);

      // recovery
      bus_start();
      write_byte({ADDR, 1'b0}, ack);
      check("R9", "ACK after recovery", ack, 1);
      expect_rx(8'hC3, 1'b1);
      write_byte(8'hC3, ack);
      check("R5", "post-recovery byte ACK", ack, 1);
      bus_stop();
      wait_cyc(10);
      check("R8", "stretch run count", runs_seen, runs_exp);
      check("R4", "all strobes seen", exp_b.size(), 0);
      check("R9", "single timeout overall", tmo_seen, 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule